// File: doc/BRIEF.md
# Line-Draw Micro-Cycle Sequencer

This block steps a line-drawing engine through a fixed micro-cycle program, one pixel at a time. Each pixel runs a short program of four or six cycles. Which program runs depends on whether the B channel is enabled. On every cycle the block reports the kind of cycle it is in. It also reports whether that cycle needs the shared memory bus. A cycle that needs the bus holds in place until the arbiter grants it.

An error accumulator and two slope increments drive the pixel stepping. A single-dot mode draws only the first pixel of each row and suppresses the memory write of the others. The block forms a texture word from the B data register, using the B shift value that is live at the time. It evaluates a three-input logic function for each pixel and keeps a zero-detect flag. When the line ends, it copies its final shift, sign and accumulator state into its visible registers.

Top module: `lndraw_seq`

## Requirements
- R1: After reset, busy_o is 0, kind_o is 0 (idle), done_o, bus_req_o and we_o are 0, and the visible registers ash_o, bsh_o, sign_o, acc_o and cdat_o are 0.
- R2: start_i is accepted only when the block is idle. With the B channel disabled, each pixel runs kind codes 1 (head), 3 (C slot), 5 (propagate) and 6 (store) in that order. After the last pixel comes one cycle of kind 7 (done), and then the block is idle again. A length of 0 runs one pixel.
- R3: With the B channel enabled, each pixel runs kind codes 1, 2 (B fetch), 3, 4 (bus only), 5 and 6 in that order.
- R4: bus_req_o is raised only while the C channel is enabled, and only on kinds 2, 3, 4 and 6. With C disabled it is never raised. The head, propagate and done cycles never raise it.
- R5: A cycle that raises bus_req_o repeats until grant_i is high. A cycle with no bus request advances on every clock.
- R6: On each propagate cycle, if A is enabled, the accumulator adds inc1_i when its bit 15 is 1 and inc2_i otherwise. If A is disabled, the accumulator does not change. The sign becomes the new bit 15. The A shift steps +1 modulo 16 and the B shift steps -1 modulo 16.
- R7: tex_o is bdat_i rotated right by the current working B shift, with no latch taken.
- R8: In single-dot mode, a dot is suppressed unless it is the first dot of its row. The first dot of a line is first of its row. A dot whose pre-update bit 15 was 0 starts a new row for the next dot. store_sup_o flags a suppressed store cycle. The store still requests the bus when C is enabled. we_o = store cycle and C enabled and not suppressed and grant_i.
- R9: On each propagate cycle, bit i of d_o becomes minterm_i[4*a+2*b+c]. Here a is bit i of 16'h8000 shifted right by the A shift, b is tex_o bit 15, and c is bit i of cdat_o. zero_o is set at start and is cleared by any nonzero d_o, including the d_o of a suppressed dot.
- R10: A granted C-slot cycle with C enabled loads cdat_o from cdata_i. cdat_o keeps its value across later lines, including lines that run with C disabled.
- R11: bptr_o loads bptr_i at start and adds bmod_i on each completed B-fetch cycle.
- R12: done_o is high for exactly the done cycle. ash_o, bsh_o, sign_o and acc_o change only at the end of that cycle, when they take the working values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a line (taken when idle) |
| len_i | input | LW | Pixel count (0 acts as 1) |
| use_a_i | input | 1 | A channel enable |
| use_b_i | input | 1 | B channel enable |
| use_c_i | input | 1 | C channel enable |
| sing_i | input | 1 | Single-dot mode |
| ash_i | input | SW | Initial A shift |
| bsh_i | input | SW | Initial B shift |
| acc_i | input | DW | Initial error accumulator |
| inc1_i | input | DW | Increment used when accumulator is negative |
| inc2_i | input | DW | Increment used otherwise |
| minterm_i | input | 8 | Logic function truth table |
| bdat_i | input | DW | B data register |
| cdata_i | input | DW | Data returned by a C fetch |
| bptr_i | input | PW | Initial B pointer |
| bmod_i | input | PW | B modulo |
| grant_i | input | 1 | Bus grant |
| busy_o | output | 1 | Line in progress |
| kind_o | output | 3 | Current cycle kind code |
| bus_req_o | output | 1 | Bus request this cycle |
| we_o | output | 1 | Memory write strobe |
| store_sup_o | output | 1 | Store cycle with suppressed write |
| d_o | output | DW | Logic function result of last pixel |
| tex_o | output | DW | Texture word |
| zero_o | output | 1 | Zero-detect flag |
| done_o | output | 1 | Done cycle |
| bptr_o | output | PW | B pointer |
| cdat_o | output | DW | C data register |
| ash_o | output | SW | Visible A shift |
| bsh_o | output | SW | Visible B shift |
| sign_o | output | 1 | Visible sign |
| acc_o | output | DW | Visible accumulator |

## Verification
The bench sweeps every combination of the A, B and C enables and the single-dot flag. It uses several lengths, including 0, and two accumulator sets, under a pseudo-random grant pattern. The bench model counts bus requests and cycles. A design that requested the bus with C disabled, or on the done cycle, would show extra granted requests. A design that dropped the request of a suppressed store would show fewer. A design that skipped the stall would finish in the wrong number of cycles. The bench also folds every written d_o into an XOR. That sum exposes a texture taken from a latched rather than a live B shift, and a C word that was cleared instead of retained. Suppressed-dot and zero-flag counts catch a design that let suppression block the logic update as well as the write.

// File: rtl/lndraw_pkg.sv
package lndraw_pkg;
  typedef enum logic [2:0] {
    K_IDLE  = 3'd0,
    K_HEAD  = 3'd1,
    K_FB    = 3'd2,
    K_FC    = 3'd3,
    K_BUS   = 3'd4,
    K_PROP  = 3'd5,
    K_STORE = 3'd6,
    K_DONE  = 3'd7
  } kind_e;
endpackage

// File: rtl/lndraw_ucode.sv
module lndraw_ucode
  import lndraw_pkg::*;
(
  input  logic [2:0] step_i,
  input  logic       use_b_i,
  output kind_e      kind_o,
  output logic       last_o
);
  always_comb begin
    if (use_b_i) begin
      case (step_i)
        3'd0:    kind_o = K_HEAD;
        3'd1:    kind_o = K_FB;
        3'd2:    kind_o = K_FC;
        3'd3:    kind_o = K_BUS;
        3'd4:    kind_o = K_PROP;
        default: kind_o = K_STORE;
      endcase
      last_o = (step_i == 3'd5);
    end else begin
      case (step_i)
        3'd0:    kind_o = K_HEAD;
        3'd1:    kind_o = K_FC;
        3'd2:    kind_o = K_PROP;
        default: kind_o = K_STORE;
      endcase
      last_o = (step_i == 3'd3);
    end
  end
endmodule

// File: rtl/lndraw_dp.sv
module lndraw_dp #(
  parameter int DW = 16,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [SW-1:0] ash_i,
  input  logic [SW-1:0] bsh_i,
  input  logic [DW-1:0] acc_i,
  input  logic          use_a_i,
  input  logic          sing_i,
  input  logic [DW-1:0] inc1_i,
  input  logic [DW-1:0] inc2_i,
  input  logic          pix_i,
  input  logic [DW-1:0] bdat_i,
  input  logic [DW-1:0] cdat_i,
  input  logic [7:0]    minterm_i,
  output logic [SW-1:0] ash_o,
  output logic [SW-1:0] bsh_o,
  output logic [DW-1:0] acc_o,
  output logic          sign_o,
  output logic [DW-1:0] tex_o,
  output logic [DW-1:0] d_o,
  output logic          sup_o,
  output logic          zero_o
);
  logic [SW-1:0]   ash_q, bsh_q;
  logic [DW-1:0]   acc_q, d_q, acc_nx, a_word, d_w;
  logic            sign_q, first_q, sup_q, zero_q;
  logic [2*DW-1:0] rot;

  // texture follows the live B shift
  assign rot    = {bdat_i, bdat_i} >> bsh_q;
  assign tex_o  = rot[DW-1:0];
  assign a_word = {1'b1, {(DW-1){1'b0}}} >> ash_q;
  assign acc_nx = use_a_i ? acc_q + (acc_q[DW-1] ? inc1_i : inc2_i) : acc_q;

  for (genvar i = 0; i < DW; i++) begin : g_mt
    assign d_w[i] = minterm_i[{a_word[i], tex_o[DW-1], cdat_i[i]}];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ash_q   <= '0;
      bsh_q   <= '0;
      acc_q   <= '0;
      sign_q  <= 1'b0;
      first_q <= 1'b1;
      sup_q   <= 1'b0;
      zero_q  <= 1'b1;
      d_q     <= '0;
    end else if (load_i) begin
      ash_q   <= ash_i;
      bsh_q   <= bsh_i;
      acc_q   <= acc_i;
      sign_q  <= acc_i[DW-1];
      first_q <= 1'b1;
      sup_q   <= 1'b0;
      zero_q  <= 1'b1;
      d_q     <= '0;
    end else if (pix_i) begin
      acc_q   <= acc_nx;
      sign_q  <= acc_nx[DW-1];
      ash_q   <= ash_q + SW'(1);
      bsh_q   <= bsh_q - SW'(1);
      first_q <= ~acc_q[DW-1];
      sup_q   <= sing_i & ~first_q;
      d_q     <= d_w;
      // suppression blocks only the write, not the logic update
      if (|d_w) zero_q <= 1'b0;
    end
  end

  assign ash_o  = ash_q;
  assign bsh_o  = bsh_q;
  assign acc_o  = acc_q;
  assign sign_o = sign_q;
  assign d_o    = d_q;
  assign sup_o  = sup_q;
  assign zero_o = zero_q;
endmodule

// File: rtl/lndraw_seq.sv
module lndraw_seq
  import lndraw_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 10,
  parameter int PW = 20,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          use_a_i,
  input  logic          use_b_i,
  input  logic          use_c_i,
  input  logic          sing_i,
  input  logic [SW-1:0] ash_i,
  input  logic [SW-1:0] bsh_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] inc1_i,
  input  logic [DW-1:0] inc2_i,
  input  logic [7:0]    minterm_i,
  input  logic [DW-1:0] bdat_i,
  input  logic [DW-1:0] cdata_i,
  input  logic [PW-1:0] bptr_i,
  input  logic [PW-1:0] bmod_i,
  input  logic          grant_i,
  output logic          busy_o,
  output logic [2:0]    kind_o,
  output logic          bus_req_o,
  output logic          we_o,
  output logic          store_sup_o,
  output logic [DW-1:0] d_o,
  output logic [DW-1:0] tex_o,
  output logic          zero_o,
  output logic          done_o,
  output logic [PW-1:0] bptr_o,
  output logic [DW-1:0] cdat_o,
  output logic [SW-1:0] ash_o,
  output logic [SW-1:0] bsh_o,
  output logic          sign_o,
  output logic [DW-1:0] acc_o
);
  logic          busy_q, fin_q, start_ok, adv, pix, uc_last, sup_w, sign_w;
  logic [2:0]    step_q;
  logic [LW-1:0] cnt_q;
  logic          use_a_q, use_b_q, use_c_q, sing_q;
  logic [PW-1:0] bmod_q, bptr_q;
  logic [DW-1:0] cdat_q, acc_w;
  logic [SW-1:0] ash_w, bsh_w;
  logic [SW-1:0] vis_ash_q, vis_bsh_q;
  logic          vis_sign_q;
  logic [DW-1:0] vis_acc_q;
  kind_e         uc_kind, kind_w;

  lndraw_ucode u_ucode (
    .step_i (step_q),
    .use_b_i(use_b_q),
    .kind_o (uc_kind),
    .last_o (uc_last)
  );

  assign start_ok = ~busy_q & start_i;

  always_comb begin
    if (!busy_q)    kind_w = K_IDLE;
    else if (fin_q) kind_w = K_DONE;
    else            kind_w = uc_kind;
  end

  assign bus_req_o = use_c_q & (kind_w == K_FB || kind_w == K_FC ||
                                kind_w == K_BUS || kind_w == K_STORE);
  assign adv = ~bus_req_o | grant_i;
  assign pix = (kind_w == K_PROP);

  lndraw_dp #(.DW(DW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_ok),
    .ash_i    (ash_i),
    .bsh_i    (bsh_i),
    .acc_i    (acc_i),
    .use_a_i  (use_a_q),
    .sing_i   (sing_q),
    .inc1_i   (inc1_i),
    .inc2_i   (inc2_i),
    .pix_i    (pix),
    .bdat_i   (bdat_i),
    .cdat_i   (cdat_q),
    .minterm_i(minterm_i),
    .ash_o    (ash_w),
    .bsh_o    (bsh_w),
    .acc_o    (acc_w),
    .sign_o   (sign_w),
    .tex_o    (tex_o),
    .d_o      (d_o),
    .sup_o    (sup_w),
    .zero_o   (zero_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      step_q  <= '0;
      cnt_q   <= '0;
      use_a_q <= 1'b0;
      use_b_q <= 1'b0;
      use_c_q <= 1'b0;
      sing_q  <= 1'b0;
      bmod_q  <= '0;
      bptr_q  <= '0;
    end else if (start_ok) begin
      busy_q  <= 1'b1;
      fin_q   <= 1'b0;
      step_q  <= '0;
      cnt_q   <= (len_i == '0) ? LW'(1) : len_i;
      use_a_q <= use_a_i;
      use_b_q <= use_b_i;
      use_c_q <= use_c_i;
      sing_q  <= sing_i;
      bmod_q  <= bmod_i;
      bptr_q  <= bptr_i;
    end else if (busy_q) begin
      if (fin_q) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b0;
      end else if (adv) begin
        if (kind_w == K_FB) bptr_q <= bptr_q + bmod_q;
        if (uc_last) begin
          step_q <= '0;
          if (cnt_q == LW'(1)) fin_q <= 1'b1;
          else                 cnt_q <= cnt_q - LW'(1);
        end else begin
          step_q <= step_q + 3'd1;
        end
      end
    end
  end

  // C register persists across lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cdat_q <= '0;
    else if (kind_w == K_FC && use_c_q && grant_i) cdat_q <= cdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_ash_q  <= '0;
      vis_bsh_q  <= '0;
      vis_sign_q <= 1'b0;
      vis_acc_q  <= '0;
    end else if (busy_q && fin_q) begin
      vis_ash_q  <= ash_w;
      vis_bsh_q  <= bsh_w;
      vis_sign_q <= sign_w;
      vis_acc_q  <= acc_w;
    end
  end

  assign busy_o      = busy_q;
  assign kind_o      = kind_w;
  assign done_o      = busy_q & fin_q;
  assign store_sup_o = (kind_w == K_STORE) & sup_w;
  assign we_o        = (kind_w == K_STORE) & use_c_q & ~sup_w & grant_i;
  assign bptr_o      = bptr_q;
  assign cdat_o      = cdat_q;
  assign ash_o       = vis_ash_q;
  assign bsh_o       = vis_bsh_q;
  assign sign_o      = vis_sign_q;
  assign acc_o       = vis_acc_q;
endmodule

// File: rtl/lndraw_seq_chk.sv
module lndraw_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic [2:0]    kind_o,
  input logic          bus_req_o,
  input logic          grant_i,
  input logic          done_o,
  input logic          we_o,
  input logic          store_sup_o,
  input logic [DW-1:0] acc_o,
  input logic          use_a_q,
  input logic          use_c_q,
  input logic [DW-1:0] acc_w
);
  p_done_bus_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);

  p_no_bus_no_c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !use_c_q) |-> !bus_req_o);

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !grant_i) |=> ($stable(kind_o) && bus_req_o));

  p_acc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !use_a_q) |=> $stable(acc_w));

  p_store_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && kind_o == 3'd6 && use_c_q) |-> bus_req_o);

  p_sup_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_sup_o |-> !we_o);

  p_wb_only_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(acc_o));
endmodule

bind lndraw_seq lndraw_seq_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .kind_o     (kind_o),
  .bus_req_o  (bus_req_o),
  .grant_i    (grant_i),
  .done_o     (done_o),
  .we_o       (we_o),
  .store_sup_o(store_sup_o),
  .acc_o      (acc_o),
  .use_a_q    (use_a_q),
  .use_c_q    (use_c_q),
  .acc_w      (acc_w)
);

// File: tb/lndraw_seq_bench.sv
`timescale 1ns/1ps
module lndraw_seq_bench;
  localparam int DW = 16, LW = 10, PW = 20, SW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, use_a_i = 1'b0, use_b_i = 1'b0, use_c_i = 1'b0, sing_i = 1'b0;
  logic grant_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic [SW-1:0] ash_i = '0, bsh_i = '0;
  logic [DW-1:0] acc_i = '0, inc1_i = '0, inc2_i = '0, bdat_i = '0, cdata_i = '0;
  logic [7:0]    minterm_i = '0;
  logic [PW-1:0] bptr_i = '0, bmod_i = '0;
  logic          busy_o, bus_req_o, we_o, store_sup_o, zero_o, done_o, sign_o;
  logic [2:0]    kind_o;
  logic [DW-1:0] d_o, tex_o, cdat_o, acc_o;
  logic [PW-1:0] bptr_o;
  logic [SW-1:0] ash_o, bsh_o;

  int total = 0, bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] cdat_exp = '0;

  always #4 clk_i = ~clk_i;

  lndraw_seq #(.DW(DW), .LW(LW), .PW(PW)) u_lndraw_seq (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rotr(input logic [DW-1:0] v, input logic [SW-1:0] s);
    logic [2*DW-1:0] t;
    t = {v, v} >> s;
    return t[DW-1:0];
  endfunction

  task automatic run_blit(input bit ua, input bit ub, input bit uc, input bit sg,
                          input int len, input logic [DW-1:0] acc0,
                          input logic [DW-1:0] i1, input logic [DW-1:0] i2,
                          input logic [7:0] mt, input logic [DW-1:0] cf,
                          input logic [DW-1:0] bd, input logic [SW-1:0] as0,
                          input logic [SW-1:0] bs0);
    logic [DW-1:0] acc = acc0, dx = '0, dx_got = '0, d, aw, cw, tx;
    logic [SW-1:0] as = as0, bs = bs0;
    logic [2:0] seq_exp [6];
    logic [2:0] seq_got [6];
    bit first = 1, zero = 1, sb, sup;
    int nsup = 0, nwr = 0, leff, per, reqs;
    int cyc = 0, stalls = 0, greq = 0, wr = 0, sups = 0, nseq = 0, dones = 0;
    bit fin = 0, done_req = 0;
    leff = (len == 0) ? 1 : len;
    per  = ub ? 6 : 4;
    reqs = uc ? leff * (ub ? 4 : 2) : 0;
    cw   = uc ? cf : cdat_exp;
    for (int p = 0; p < leff; p++) begin
      tx = rotr(bd, bs);
      aw = 16'h8000 >> as;
      for (int i = 0; i < DW; i++) d[i] = mt[{aw[i], tx[DW-1], cw[i]}];
      if (d != 0) zero = 0;
      sup = sg & ~first;
      if (sup) nsup++;
      else if (uc) begin nwr++; dx ^= d; end
      sb = acc[DW-1];
      if (ua) acc = acc + (sb ? i1 : i2);
      as = as + 1'b1;
      bs = bs - 1'b1;
      first = ~sb;
    end
    if (ub) begin
      seq_exp[0] = 1; seq_exp[1] = 2; seq_exp[2] = 3;
      seq_exp[3] = 4; seq_exp[4] = 5; seq_exp[5] = 6;
    end else begin
      seq_exp[0] = 1; seq_exp[1] = 3; seq_exp[2] = 5;
      seq_exp[3] = 6; seq_exp[4] = 0; seq_exp[5] = 0;
    end
    @(negedge clk_i);
    use_a_i = ua; use_b_i = ub; use_c_i = uc; sing_i = sg;
    len_i = LW'(len); acc_i = acc0; inc1_i = i1; inc2_i = i2; minterm_i = mt;
    cdata_i = cf; bdat_i = bd; ash_i = as0; bsh_i = bs0;
    bptr_i = 20'h01000; bmod_i = 20'h00044; start_i = 1'b1;
    @(posedge clk_i); #1 start_i = 1'b0;
    while (!fin && cyc < 300) begin
      @(negedge clk_i);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      grant_i = lfsr[0] | lfsr[3];
      #1;
      if (cyc == 0) chk(tex_o == rotr(bd, bs0), "R7", "texture", tex_o, rotr(bd, bs0));
      cyc++;
      if (bus_req_o && !grant_i) stalls++;
      if (bus_req_o && grant_i) greq++;
      if (we_o) begin wr++; dx_got ^= d_o; end
      if (store_sup_o && (!bus_req_o || grant_i)) sups++;
      if ((!bus_req_o || grant_i) && nseq < per) begin seq_got[nseq] = kind_o; nseq++; end
      if (done_o) begin
        dones++;
        done_req = bus_req_o;
        chk(kind_o == 3'd7, "R2", "done kind", 32'(kind_o), 7);
        fin = 1;
      end
    end
    chk(fin, "R2", "line finished", 32'(fin), 1);
    for (int k = 0; k < per; k++)
      chk(seq_got[k] == seq_exp[k], ub ? "R3" : "R2", "kind order", 32'(seq_got[k]), 32'(seq_exp[k]));
    chk(!done_req, "R4", "done cycle bus idle", 32'(done_req), 0);
    chk(greq == reqs, "R4", "granted requests", greq, reqs);
    chk(cyc == per * leff + 1 + stalls, "R5", "cycle count", cyc, per * leff + 1 + stalls);
    chk(sups == nsup, "R8", "suppressed stores", sups, nsup);
    chk(wr == nwr, "R8", "writes", wr, nwr);
    chk(dx_got == dx, "R9", "written data xor", dx_got, dx);
    @(negedge clk_i); #1;
    chk(!busy_o && kind_o == 3'd0, "R2", "idle after done", {busy_o, kind_o}, 0);
    chk(acc_o == acc, "R6", "accumulator", acc_o, acc);
    chk(sign_o == acc[DW-1], "R6", "sign", 32'(sign_o), 32'(acc[DW-1]));
    chk(ash_o == as && bsh_o == bs, "R12", "shift writeback", {ash_o, bsh_o}, {as, bs});
    chk(zero_o == zero, "R9", "zero flag", 32'(zero_o), 32'(zero));
    chk(bptr_o == 20'h01000 + (ub ? leff * 20'h44 : 0), "R11", "B pointer",
        bptr_o, 20'h01000 + (ub ? leff * 20'h44 : 0));
    if (uc) cdat_exp = cf;
    chk(cdat_o == cdat_exp, "R10", "C register", cdat_o, cdat_exp);
  endtask

  initial begin
    #1_000_000;
    chk(0, "ALL", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx = 0;
    #20;
    chk(!busy_o && kind_o == 0 && !done_o && !bus_req_o && !we_o, "R1", "reset outputs",
        {busy_o, kind_o, done_o, bus_req_o, we_o}, 0);
    chk(acc_o == 0 && ash_o == 0 && bsh_o == 0 && !sign_o && cdat_o == 0, "R1",
        "reset visible regs", acc_o, 0);
    rst_ni = 1'b1;
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int li = 0; li < 3; li++) begin
        for (int set = 0; set < 2; set++) begin
          int len = (li == 0) ? 1 : (li == 1) ? 2 : 5;
          idx++;
          if (set == 0)
            run_blit(cfg[0], cfg[1], cfg[2], cfg[3], len, 16'hFFF0, 16'h0006, 16'hFFF4,
                     8'hCA ^ 8'(idx), 16'h1000 + 16'(idx), 16'hA5C3, 4'(idx), 4'(idx * 3));
          else
            run_blit(cfg[0], cfg[1], cfg[2], cfg[3], len, 16'h0003, 16'h0010, 16'hFFFB,
                     8'h96 ^ 8'(idx * 5), 16'h2200 + 16'(idx), 16'h3C81, 4'(15 - idx), 4'(idx));
        end
      end
    end
    run_blit(1, 1, 1, 1, 0, 16'h8001, 16'h0002, 16'h0003, 8'hF0, 16'h0BAD, 16'h00FF, 4'd2, 4'd7);
    run_blit(1, 0, 0, 0, 3, 16'h0001, 16'h0001, 16'hFFFE, 8'hAA, 16'h7777, 16'h1234, 4'd0, 4'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule